// File: doc/BRIEF.md
# Legacy Address Mode Checker

This block sits on the access path between a processor core and memory. It enforces the compatibility rules of a legacy 26-bit addressing model. Two configuration flags drive it. The wide-program flag selects whether the core may run 32-bit code at all. The wide-data flag selects whether legacy code may reach data beyond 64MB.

Each cycle the block takes one access descriptor: a valid strobe, the address, whether the access is a fetch or a data access, and whether it is a read or a write. It also takes the top bit of the current mode field, a per-bit write request for the mode field, and the program counter. It raises two separate traps:
- an address exception on out-of-range legacy data addresses;
- a vector exception on data accesses to the exception vector table made from a legacy mode.

It also suppresses writes that would switch the core into a 32-bit mode, trims the program counter to the legacy range, and reports the mode that abort and undefined-instruction handling must enter. Every output is registered and belongs to the request presented one clock earlier.

Top module: `legacy_addr_guard`

## Requirements
- R1: With `cfg_prog32` low, bits 4, 3 and 2 of `sr_wr_en_o` are 0 whatever `sr_wr_req` holds, and bits 1 and 0 follow `sr_wr_req`. With `cfg_prog32` high, `sr_wr_en_o` equals `sr_wr_req`.
- R2: With `cfg_prog32` low, `pc_o` equals `pc_i` AND 0x03FFFFFC, which keeps a 24-bit word address covering 64MB. With `cfg_prog32` high, `pc_o` equals `pc_i`.
- R3: An address exception (`addr_exc_o`) is raised when all of these hold: `cfg_prog32` low, `cfg_data32` low, a valid data access, and a 1 in any of address bits 31 to 26. Address 0x03FFFFFF does not trap. Address 0x04000000 does trap.
- R4: With `cfg_prog32` low and `cfg_data32` high, no data address raises an address exception.
- R5: A vector exception (`vec_exc_o`) is raised when all of these hold: `cfg_prog32` high, `mode_b4_i` low, a valid data write, and an address from 0x00 to 0x1F. Address 0x20 does not trap, and neither does any write while `mode_b4_i` is high.
- R6: Instruction fetches (`acc_fetch` high) never raise either exception, at any address.
- R7: Data reads of 0x00 to 0x1F raise a vector exception only when the parameter READ_TRAP is 1. With the default value 0, reads never raise it.
- R8: Both exceptions are single-cycle pulses that appear one clock after the access, together with `acc_valid_o`. No exception is raised without a valid access.
- R9: The two exceptions are never high in the same cycle. The address exception takes precedence.
- R10: `exc_mode_o` is 5'b00011 (legacy supervisor) when `cfg_prog32` is low and 5'b10011 (32-bit supervisor) when it is high, one clock after the flag is sampled.
- R11: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_prog32 | input | 1 | Wide-program configuration flag |
| cfg_data32 | input | 1 | Wide-data configuration flag |
| mode_b4_i | input | 1 | Bit 4 of the current mode field (0 = legacy mode) |
| acc_valid | input | 1 | Access descriptor valid |
| acc_addr | input | 32 | Access byte address |
| acc_fetch | input | 1 | 1 = instruction fetch, 0 = data access |
| acc_write | input | 1 | 1 = write, 0 = read |
| sr_wr_req | input | 5 | Per-bit write request for the mode field |
| pc_i | input | 32 | Program counter from the core |
| acc_valid_o | output | 1 | Registered access valid |
| addr_exc_o | output | 1 | Address exception pulse |
| vec_exc_o | output | 1 | Vector exception pulse |
| sr_wr_en_o | output | 5 | Filtered per-bit mode write enable |
| pc_o | output | 32 | Masked program counter |
| exc_mode_o | output | 5 | Mode for abort and undefined handling |

## Verification
The bench works on the edges of the two windows: 0x1F against 0x20, and 0x03FFFFFF against 0x04000000. It tries them under all four flag combinations. If a comparison is off by one, one of these boundary addresses traps wrongly. If a flag is ignored, a wide-data or wide-program configuration traps legacy-range accesses.

Fetches and reads aimed at the vector table are mixed in. A design that leaves out the fetch or direction qualifier flags harmless accesses as aborts. Random write requests against the locked mode bits expose a filter that lets bit 2, 3 or 4 through. Random program counters expose a mask that clips the wrong bits.

// File: rtl/lag_pkg.sv
package lag_pkg;
   localparam int MODE_W = 5;
   localparam logic [MODE_W-1:0] SVC_LEGACY = 5'b00011;
   localparam logic [MODE_W-1:0] SVC_WIDE   = 5'b10011;

   typedef struct packed {
      logic addr_exc;
      logic vec_exc;
   } lag_trap_t;
endpackage

// File: rtl/lag_range_chk.sv
module lag_range_chk #(
   parameter int HI_BITS = 6
) (
   input  logic               data_acc,
   input  logic               prog32,
   input  logic               data32,
   input  logic [HI_BITS-1:0] addr_hi,
   output logic               hit
);
   generate
      if (HI_BITS > 0) begin : g_chk
         always_comb hit = data_acc & ~prog32 & ~data32 & (|addr_hi);
      end else begin : g_none
         always_comb hit = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/lag_vec_chk.sv
module lag_vec_chk #(
   parameter int ADDR_W    = 32,
   parameter int VEC_LIMIT = 32,
   parameter bit READ_TRAP = 1'b0
) (
   input  logic              data_acc,
   input  logic              is_write,
   input  logic              prog32,
   input  logic              mode_b4,
   input  logic [ADDR_W-1:0] addr,
   output logic              hit
);
   localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(VEC_LIMIT);
   logic in_win;
   logic dir_ok;

   always_comb in_win = (addr < LIMIT);

   generate
      if (READ_TRAP) begin : g_rd_trap
         always_comb dir_ok = 1'b1;
      end else begin : g_wr_only
         always_comb dir_ok = is_write;
      end
   endgenerate

   always_comb hit = data_acc & prog32 & ~mode_b4 & in_win & dir_ok;
endmodule

// File: rtl/lag_mode_filter.sv
module lag_mode_filter #(
   parameter int MODE_W    = 5,
   parameter int LOCK_LO   = 2,
   parameter int LOCK_HI   = 4,
   parameter int ADDR_W    = 32,
   parameter int PC_KEEP_W = 26
) (
   input  logic              prog32,
   input  logic [MODE_W-1:0] wr_req,
   input  logic [ADDR_W-1:0] pc_in,
   output logic [MODE_W-1:0] wr_en,
   output logic [ADDR_W-1:0] pc_out,
   output logic [MODE_W-1:0] hdl_mode
);
   import lag_pkg::*;
   localparam logic [ADDR_W-1:0] PC_MASK =
      ((ADDR_W'(1) << PC_KEEP_W) - ADDR_W'(1)) & ~ADDR_W'(3);

   genvar b;
   generate
      for (b = 0; b < MODE_W; b++) begin : g_bit
         if (b >= LOCK_LO && b <= LOCK_HI) begin : g_lock
            always_comb wr_en[b] = wr_req[b] & prog32;
         end else begin : g_free
            always_comb wr_en[b] = wr_req[b];
         end
      end
   endgenerate

   always_comb begin
      pc_out   = prog32 ? pc_in : (pc_in & PC_MASK);
      hdl_mode = prog32 ? MODE_W'(SVC_WIDE) : MODE_W'(SVC_LEGACY);
   end
endmodule

// File: rtl/legacy_addr_guard.sv
module legacy_addr_guard #(
   parameter int ADDR_W    = 32,
   parameter int HI_BITS   = 6,
   parameter int VEC_LIMIT = 32,
   parameter bit READ_TRAP = 1'b0,
   parameter int MODE_W    = 5,
   parameter int LOCK_LO   = 2,
   parameter int LOCK_HI   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_prog32,
   input  logic              cfg_data32,
   input  logic              mode_b4_i,
   input  logic              acc_valid,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic              acc_fetch,
   input  logic              acc_write,
   input  logic [MODE_W-1:0] sr_wr_req,
   input  logic [ADDR_W-1:0] pc_i,
   output logic              acc_valid_o,
   output logic              addr_exc_o,
   output logic              vec_exc_o,
   output logic [MODE_W-1:0] sr_wr_en_o,
   output logic [ADDR_W-1:0] pc_o,
   output logic [MODE_W-1:0] exc_mode_o
);
   import lag_pkg::*;
   localparam int PC_KEEP_W = ADDR_W - HI_BITS;

   generate
      if (HI_BITS < 1 || HI_BITS >= ADDR_W) begin : g_bad_hi
         $error("HI_BITS must lie between 1 and ADDR_W-1");
      end
      if (VEC_LIMIT < 1 || (VEC_LIMIT & (VEC_LIMIT - 1)) != 0) begin : g_bad_vec
         $error("VEC_LIMIT must be a power of two");
      end
      if (LOCK_HI >= MODE_W || LOCK_LO > LOCK_HI) begin : g_bad_lock
         $error("lock range outside mode field");
      end
   endgenerate

   logic              data_acc;
   logic              rng_hit;
   logic              vec_hit;
   lag_trap_t         trap_d;
   logic [MODE_W-1:0] wr_en_d;
   logic [ADDR_W-1:0] pc_d;
   logic [MODE_W-1:0] hdl_mode_d;

   always_comb data_acc = acc_valid & ~acc_fetch;

   lag_range_chk #(.HI_BITS(HI_BITS)) u_range (
      .data_acc (data_acc),
      .prog32   (cfg_prog32),
      .data32   (cfg_data32),
      .addr_hi  (acc_addr[ADDR_W-1 -: HI_BITS]),
      .hit      (rng_hit)
   );

   lag_vec_chk #(.ADDR_W(ADDR_W), .VEC_LIMIT(VEC_LIMIT), .READ_TRAP(READ_TRAP)) u_vec (
      .data_acc (data_acc),
      .is_write (acc_write),
      .prog32   (cfg_prog32),
      .mode_b4  (mode_b4_i),
      .addr     (acc_addr),
      .hit      (vec_hit)
   );

   lag_mode_filter #(.MODE_W(MODE_W), .LOCK_LO(LOCK_LO), .LOCK_HI(LOCK_HI),
                     .ADDR_W(ADDR_W), .PC_KEEP_W(PC_KEEP_W)) u_filt (
      .prog32   (cfg_prog32),
      .wr_req   (sr_wr_req),
      .pc_in    (pc_i),
      .wr_en    (wr_en_d),
      .pc_out   (pc_d),
      .hdl_mode (hdl_mode_d)
   );

   // Address trap outranks vector trap.
   always_comb begin
      trap_d.addr_exc = rng_hit;
      trap_d.vec_exc  = vec_hit & ~rng_hit;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_valid_o <= 1'b0;
         addr_exc_o  <= 1'b0;
         vec_exc_o   <= 1'b0;
         sr_wr_en_o  <= '0;
         pc_o        <= '0;
         exc_mode_o  <= '0;
      end else begin
         acc_valid_o <= acc_valid;
         addr_exc_o  <= trap_d.addr_exc;
         vec_exc_o   <= trap_d.vec_exc;
         sr_wr_en_o  <= wr_en_d;
         pc_o        <= pc_d;
         exc_mode_o  <= hdl_mode_d;
      end
   end
endmodule

// File: rtl/legacy_addr_guard_sva.sv
module legacy_addr_guard_sva #(
   parameter int ADDR_W  = 32,
   parameter int HI_BITS = 6,
   parameter int MODE_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cfg_prog32,
   input logic              cfg_data32,
   input logic              acc_valid,
   input logic [ADDR_W-1:0] acc_addr,
   input logic              acc_fetch,
   input logic              acc_valid_o,
   input logic              addr_exc_o,
   input logic              vec_exc_o,
   input logic [MODE_W-1:0] sr_wr_en_o,
   input logic [ADDR_W-1:0] pc_o
);
   assert_locked_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_prog32) |-> (sr_wr_en_o[4:2] == 3'b000));

   assert_pc_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(cfg_prog32) |-> (pc_o[ADDR_W-1 -: HI_BITS] == '0 && pc_o[1:0] == 2'b00));

   assert_addr_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
      addr_exc_o |-> ($past(!cfg_prog32 && !cfg_data32 && |acc_addr[ADDR_W-1 -: HI_BITS])));

   assert_no_fetch_trap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_exc_o || vec_exc_o) |-> !$past(acc_fetch));

   assert_pulse_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_exc_o || vec_exc_o) |-> (acc_valid_o && $past(acc_valid)));

   assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({addr_exc_o, vec_exc_o}));
endmodule

bind legacy_addr_guard legacy_addr_guard_sva #(.ADDR_W(ADDR_W), .HI_BITS(HI_BITS), .MODE_W(MODE_W)) u_sva (
   .clk(clk), .rst_n(rst_n), .cfg_prog32(cfg_prog32), .cfg_data32(cfg_data32),
   .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_fetch(acc_fetch),
   .acc_valid_o(acc_valid_o), .addr_exc_o(addr_exc_o), .vec_exc_o(vec_exc_o),
   .sr_wr_en_o(sr_wr_en_o), .pc_o(pc_o)
);

// File: tb/legacy_addr_guard_tb_top.sv
`timescale 1ns/1ps
module legacy_addr_guard_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_prog32 = 0, cfg_data32 = 0, mode_b4_i = 0;
   logic        acc_valid = 0, acc_fetch = 0, acc_write = 0;
   logic [31:0] acc_addr = '0, pc_i = '0;
   logic [4:0]  sr_wr_req = '0;
   logic        acc_valid_o, addr_exc_o, vec_exc_o;
   logic [4:0]  sr_wr_en_o, exc_mode_o;
   logic [31:0] pc_o;
   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #5 clk = ~clk;

   legacy_addr_guard dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_prog32(cfg_prog32), .cfg_data32(cfg_data32),
      .mode_b4_i(mode_b4_i), .acc_valid(acc_valid), .acc_addr(acc_addr),
      .acc_fetch(acc_fetch), .acc_write(acc_write), .sr_wr_req(sr_wr_req),
      .pc_i(pc_i), .acc_valid_o(acc_valid_o), .addr_exc_o(addr_exc_o),
      .vec_exc_o(vec_exc_o), .sr_wr_en_o(sr_wr_en_o), .pc_o(pc_o),
      .exc_mode_o(exc_mode_o)
   );

   function automatic bit f_addr(bit p32, bit d32, bit v, bit f, logic [31:0] a);
      return v && !f && !p32 && !d32 && (a[31:26] != 6'd0);
   endfunction

   function automatic bit f_vec(bit p32, bit d32, bit m4, bit v, bit f, bit w, logic [31:0] a);
      if (f_addr(p32, d32, v, f, a)) return 1'b0;
      return v && !f && p32 && !m4 && w && (a < 32'h20);
   endfunction

   function automatic logic [4:0] f_sr(bit p32, logic [4:0] r);
      return p32 ? r : (r & 5'b00011);
   endfunction

   function automatic logic [31:0] f_pc(bit p32, logic [31:0] p);
      return p32 ? p : (p & 32'h03FF_FFFC);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic drive(input bit p32, input bit d32, input bit m4, input bit v,
                        input bit f, input bit w, input logic [31:0] a,
                        input logic [4:0] r, input logic [31:0] p);
      @(negedge clk);
      cfg_prog32 = p32; cfg_data32 = d32; mode_b4_i = m4; acc_valid = v;
      acc_fetch = f; acc_write = w; acc_addr = a; sr_wr_req = r; pc_i = p;
      @(posedge clk);
      #1;
      chk("R3/R4 addr_exc", 32'(addr_exc_o), 32'(f_addr(p32, d32, v, f, a)));
      chk("R5/R6/R7/R9 vec_exc", 32'(vec_exc_o), 32'(f_vec(p32, d32, m4, v, f, w, a)));
      chk("R8 valid_o", 32'(acc_valid_o), 32'(v));
      chk("R1 sr_wr_en", 32'(sr_wr_en_o), 32'(f_sr(p32, r)));
      chk("R2 pc", pc_o, f_pc(p32, p));
      chk("R10 exc_mode", 32'(exc_mode_o), p32 ? 32'h13 : 32'h03);
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] edges [6];
      void'($urandom(32'd4242));
      edges[0] = 32'h0; edges[1] = 32'h1F; edges[2] = 32'h20;
      edges[3] = 32'h03FF_FFFF; edges[4] = 32'h0400_0000; edges[5] = 32'hFFFF_FFFC;
      sr_wr_req = 5'h1F; pc_i = 32'hFFFF_FFFF; acc_valid = 1; cfg_prog32 = 1;
      repeat (3) @(posedge clk);
      #1;
      // R11 reset state
      chk("R11 reset valid", 32'(acc_valid_o), 0);
      chk("R11 reset exc", 32'({addr_exc_o, vec_exc_o}), 0);
      chk("R11 reset sr/pc/mode", 32'(sr_wr_en_o) | pc_o | 32'(exc_mode_o), 0);
      @(negedge clk);
      rst_n = 1;
      // Directed corners: all four flag combinations on boundary addresses
      for (int cfg = 0; cfg < 4; cfg++) begin
         for (int e = 0; e < 6; e++) begin
            drive(cfg[1], cfg[0], 1'b0, 1'b1, 1'b0, 1'b1, edges[e], 5'h1F, 32'hFFFF_FFFF); // data write
            drive(cfg[1], cfg[0], 1'b0, 1'b1, 1'b0, 1'b0, edges[e], 5'h1C, 32'h8765_4321); // data read, R7
            drive(cfg[1], cfg[0], 1'b0, 1'b1, 1'b1, 1'b1, edges[e], 5'h03, edges[e]);      // fetch, R6
            drive(cfg[1], cfg[0], 1'b1, 1'b1, 1'b0, 1'b1, edges[e], 5'h04, 32'h0);         // mode bit 4 set, R5
         end
      end
      // Explicit boundary checks by name
      drive(1, 0, 0, 1, 0, 1, 32'h1F, 5'h0, 32'h0);
      chk("R5 write 0x1F traps", 32'(vec_exc_o), 1);
      drive(1, 0, 0, 1, 0, 1, 32'h20, 5'h0, 32'h0);
      chk("R5 write 0x20 clean", 32'(vec_exc_o), 0);
      drive(0, 0, 0, 1, 0, 0, 32'h0400_0000, 5'h0, 32'h0);
      chk("R3 0x04000000 traps", 32'(addr_exc_o), 1);
      drive(0, 0, 0, 1, 0, 0, 32'h03FF_FFFF, 5'h0, 32'h0);
      chk("R3 0x03FFFFFF clean", 32'(addr_exc_o), 0);
      drive(0, 1, 0, 1, 0, 1, 32'hFFFF_FFFF, 5'h0, 32'h0);
      chk("R4 wide data clean", 32'(addr_exc_o), 0);
      drive(0, 0, 0, 0, 0, 1, 32'hFC00_0000, 5'h0, 32'h0);
      chk("R8 no valid no trap", 32'(addr_exc_o), 0);
      drive(0, 0, 0, 1, 0, 1, 32'h0800_0000, 5'h0, 32'h0);
      drive(0, 0, 0, 1, 0, 1, 32'h0000_0100, 5'h0, 32'h0);
      chk("R8 single pulse", 32'(addr_exc_o), 0);
      // Constrained random
      for (int i = 0; i < 600; i++) begin
         logic [31:0] a;
         a = ($urandom % 2) ? edges[$urandom % 6] : $urandom;
         drive($urandom % 2, $urandom % 2, $urandom % 2, ($urandom % 8) != 0,
               ($urandom % 4) == 0, $urandom % 2, a, 5'($urandom), $urandom);
      end
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule